// File: doc/BRIEF.md
# I2C Byte-Level Bus Master

This block is a single-master engine for a two-wire I2C bus. It drives the clock and data lines as open-drain pins: each pin has a pull-low enable output and a sampled input, and a released line is pulled high outside the chip. A host gives it one bus primitive at a time: a START condition, a STOP condition, a byte write or a byte read. Each primitive ends with a one-cycle completion pulse. The pulse comes with an error flag, the acknowledge bit the slave returned on a write, and the byte collected on a read.

Every bus phase is timed in whole microseconds. A microsecond is a fixed number of reference clock ticks (`TICKS_PER_US`). The programmable `cfg_extra_us` is added to every timed wait, so the same engine can run slow buses. Each time the engine lets SCL rise, it polls the released line. A slave may hold the clock low (clock stretching): the engine then retries every microsecond until a programmable retry limit is passed.

For reads, the acknowledge the master sends is chosen by a policy. It can be forced to NACK, or it can be NACK only when the received byte differs from a supplied compare byte, or it can be a plain ACK. Repeated START, arbitration between masters and register-level transactions are left to the host, which strings primitives together.

Top module: `i2c_byte_master`

The controller is a single state machine. Its states are:
- IDLE
- START_CHK: the SDA-free test.
- SCL_RISE: release SCL, settle, poll and retry. This state is shared by every clock rise.
- START_HOLD and START_LOW
- STOP_SETUP and STOP_BUF
- BIT_SETUP, BIT_HIGH and BIT_LOW
- ACK_SETUP, ACK_HIGH and ACK_LOW
- DONE

Its transitions are:
- IDLE goes to START_CHK, to SCL_RISE (for STOP), to BIT_SETUP (for byte commands), or straight to DONE (for a rejected byte command).
- START_CHK goes to SCL_RISE, or to DONE on a busy bus.
- SCL_RISE returns to the state that called it, or goes to DONE on a timeout.
- START_HOLD goes to START_LOW, which goes to DONE.
- STOP_SETUP goes to STOP_BUF, which goes to DONE.
- BIT_SETUP goes to SCL_RISE, which returns to BIT_HIGH. BIT_HIGH goes to BIT_LOW.
- BIT_LOW goes back to BIT_SETUP for the next bit, or to ACK_SETUP after the eighth bit.
- ACK_SETUP goes to SCL_RISE, which returns to ACK_HIGH. ACK_HIGH goes to ACK_LOW, which goes to DONE.
- DONE goes to IDLE.

A wait of `n` µs below lasts exactly `(n + cfg_extra_us) * TICKS_PER_US` clock cycles. The inputs pass through a two-stage synchroniser, so a released line is sampled 3 cycles after release.

## Requirements
- R1: After reset, neither line is pulled low, `cmd_ready` is 1 and `done` is 0.
- R2: START first releases SDA and samples it 3 cycles later. If SDA reads low, the command ends with `err` = 1 and SCL is left released.
- R3: A successful START pulls SDA low and then pulls SCL low one 4 µs wait later. It finishes after a further 5 µs wait, with both lines left pulled low and `err` = 0.
- R4: STOP pulls SDA low and releases SCL. On an unstretched bus, SDA is released 3 cycles plus one 4 µs wait after SCL is released. STOP then finishes after a 5 µs wait with both lines released.
- R5: A write or read that is accepted while the synchronised SCL is high completes on the next cycle with `err` = 1, and neither line changes.
- R6: A write sends its byte most significant bit first, on SCL rising edges. Each unstretched SCL high phase lasts 3 cycles plus one 4 µs wait. SDA does not change while the master holds SCL high.
- R7: After a write, the SDA value sampled during the ninth clock is reported on `ack_nack` (1 = NACK). SDA is then pulled low to hold the bus.
- R8: A read returns on `rx_data` the eight bits seen on SDA. The first bit received becomes bit 7.
- R9: The master drives a read acknowledge on the ninth clock, with SDA released meaning NACK. The acknowledge is NACK when `cmd_force_nack` is 1. Otherwise, when `cmd_cmp_en` is 1, it is NACK only if the byte differs from `cmd_cmp_byte`. Otherwise it is ACK (SDA low).
- R10: While a released SCL reads low, the engine waits 1 µs and retries. It gives up only when a low sample is seen after more than `cfg_stretch_limit` retries. A limit of 0 means 25.
- R11: When a stretch timeout ends a write or read, `err` = 1 and SDA is left pulled low.
- R12: `cmd_op` selects the command: 0 START, 1 STOP, 2 WRITE, 3 READ. A command is accepted only while `cmd_ready` is 1, and `cmd_ready` is 1 only when idle. `done` is a single-cycle pulse, and `err` and the results are valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command taken this cycle |
| cmd_op | input | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmd_wdata | input | 8 | Byte to write |
| cmd_force_nack | input | 1 | Read: always answer NACK |
| cmd_cmp_en | input | 1 | Read: answer NACK on compare mismatch |
| cmd_cmp_byte | input | 8 | Read: compare value |
| cfg_extra_us | input | EXTRA_W | Extra microseconds added to every wait |
| cfg_stretch_limit | input | LIMIT_W | Stretch retry limit, 0 selects 25 |
| done | output | 1 | Command complete pulse |
| err | output | 1 | Command failed, valid with done |
| ack_nack | output | 1 | Write acknowledge sampled, 1 = NACK |
| rx_data | output | 8 | Byte received by a read |
| scl_drive_low | output | 1 | Pull SCL low |
| scl_in | input | 1 | SCL line level |
| sda_drive_low | output | 1 | Pull SDA low |
| sda_in | input | 1 | SDA line level |

## Verification
The hardest conditions to reach from the ports are clock stretching and its timeout. These depend on a slave holding SCL low for a number of cycles placed just inside or just outside the retry window. The bench models the slave as an open-drain participant on a shared wired-AND line. It holds SCL low from before a write begins and releases it after a fixed count of cycles, chosen so that a limit of 3 passes, a zero limit (meaning 25) passes a longer hold, and an endless hold times out. Exhaustive write and read sweeps over all 256 byte values cover the acknowledge policies, and timing gaps are measured from the pin edges.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START_CHK,
        S_SCL_RISE,
        S_START_HOLD,
        S_START_LOW,
        S_STOP_SETUP,
        S_STOP_BUF,
        S_BIT_SETUP,
        S_BIT_HIGH,
        S_BIT_LOW,
        S_ACK_SETUP,
        S_ACK_HIGH,
        S_ACK_LOW,
        S_DONE
    } state_e;

endpackage

// File: rtl/i2c_in_sync.sv
module i2c_in_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    // Released lines idle high, so every stage resets to one.
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '1;
                else        stg[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '1;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/i2c_wait_timer.sv
module i2c_wait_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int TICKS_PER_US = 27,
    parameter int EXTRA_W      = 8,
    parameter int LIMIT_W      = 8,
    parameter int DEF_LIMIT    = 25,
    parameter int SYNC_STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [1:0]         cmd_op,
    input  logic [7:0]         cmd_wdata,
    input  logic               cmd_force_nack,
    input  logic               cmd_cmp_en,
    input  logic [7:0]         cmd_cmp_byte,
    input  logic [EXTRA_W-1:0] cfg_extra_us,
    input  logic [LIMIT_W-1:0] cfg_stretch_limit,
    output logic               done,
    output logic               err,
    output logic               ack_nack,
    output logic [7:0]         rx_data,
    output logic               scl_drive_low,
    input  logic               scl_in,
    output logic               sda_drive_low,
    input  logic               sda_in
);
    localparam int SETTLE = SYNC_STAGES + 1;
    localparam int CNT_W  = $clog2((5 + (1 << EXTRA_W)) * TICKS_PER_US + SETTLE + 1);
    localparam int RTY_W  = LIMIT_W + 1;
    localparam logic [CNT_W-1:0] SETTLE_VAL = CNT_W'(SETTLE - 1);

    logic scl_s, sda_s;

    i2c_in_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_in, sda_in}),
        .dout ({scl_s, sda_s})
    );

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_exp;

    i2c_wait_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_exp)
    );

    state_e           state, state_n, rise_ret, rise_ret_n;
    op_e              cur_op, cur_op_n;
    logic             scl_lo, scl_lo_n, sda_lo, sda_lo_n;
    logic             err_r, err_n, nack_r, nack_n;
    logic [7:0]       shreg, shreg_n, rx_r, rx_n, cmp_r, cmp_n;
    logic             force_r, force_n, cmp_en_r, cmp_en_n;
    logic [2:0]       bit_cnt, bit_cnt_n;
    logic [RTY_W-1:0] rty, rty_n;
    logic [RTY_W-1:0] eff_limit;
    logic             is_byte, is_write, rd_nack;

    // Ticks minus one for a wait of us microseconds plus the extra delay.
    function automatic logic [CNT_W-1:0] us_wait(input logic [2:0] us);
        return (CNT_W'(us) + CNT_W'(cfg_extra_us)) * CNT_W'(TICKS_PER_US) - CNT_W'(1);
    endfunction

    assign eff_limit = (cfg_stretch_limit == '0) ? RTY_W'(DEF_LIMIT)
                                                 : {1'b0, cfg_stretch_limit};
    assign is_write  = (cur_op == OP_WRITE);
    assign is_byte   = (cur_op == OP_WRITE) || (cur_op == OP_READ);
    assign rd_nack   = force_r ? 1'b1 : (cmp_en_r ? (shreg != cmp_r) : 1'b0);

    // Next-state and datapath decisions.
    always_comb begin
        state_n    = state;
        rise_ret_n = rise_ret;
        cur_op_n   = cur_op;
        scl_lo_n   = scl_lo;
        sda_lo_n   = sda_lo;
        err_n      = err_r;
        nack_n     = nack_r;
        shreg_n    = shreg;
        rx_n       = rx_r;
        cmp_n      = cmp_r;
        force_n    = force_r;
        cmp_en_n   = cmp_en_r;
        bit_cnt_n  = bit_cnt;
        rty_n      = rty;
        tmr_load   = 1'b0;
        tmr_val    = SETTLE_VAL;

        unique case (state)
            S_IDLE: begin
                if (cmd_valid) begin
                    cur_op_n = op_e'(cmd_op);
                    err_n    = 1'b0;
                    force_n  = cmd_force_nack;
                    cmp_en_n = cmd_cmp_en;
                    cmp_n    = cmd_cmp_byte;
                    unique case (op_e'(cmd_op))
                        OP_START: begin
                            sda_lo_n = 1'b0;
                            tmr_load = 1'b1;
                            state_n  = S_START_CHK;
                        end
                        OP_STOP: begin
                            sda_lo_n   = 1'b1;
                            scl_lo_n   = 1'b0;
                            rty_n      = '0;
                            rise_ret_n = S_STOP_SETUP;
                            tmr_load   = 1'b1;
                            state_n    = S_SCL_RISE;
                        end
                        default: begin
                            if (scl_s) begin
                                err_n   = 1'b1;
                                state_n = S_DONE;
                            end else begin
                                bit_cnt_n = '0;
                                if (op_e'(cmd_op) == OP_WRITE) begin
                                    shreg_n  = cmd_wdata;
                                    sda_lo_n = ~cmd_wdata[7];
                                end else begin
                                    shreg_n  = '0;
                                    sda_lo_n = 1'b0;
                                end
                                tmr_load = 1'b1;
                                tmr_val  = us_wait(3'd1);
                                state_n  = S_BIT_SETUP;
                            end
                        end
                    endcase
                end
            end
            S_START_CHK: begin
                if (tmr_exp) begin
                    if (!sda_s) begin
                        err_n   = 1'b1;
                        state_n = S_DONE;
                    end else begin
                        scl_lo_n   = 1'b0;
                        rty_n      = '0;
                        rise_ret_n = S_START_HOLD;
                        tmr_load   = 1'b1;
                        state_n    = S_SCL_RISE;
                    end
                end
            end
            S_SCL_RISE: begin
                if (tmr_exp) begin
                    if (scl_s) begin
                        tmr_load = 1'b1;
                        tmr_val  = us_wait(3'd4);
                        if (rise_ret == S_START_HOLD) sda_lo_n = 1'b1;
                        state_n  = rise_ret;
                    end else if (rty > eff_limit) begin
                        err_n = 1'b1;
                        if (is_byte) sda_lo_n = 1'b1;
                        state_n = S_DONE;
                    end else begin
                        rty_n    = rty + RTY_W'(1);
                        tmr_load = 1'b1;
                        tmr_val  = us_wait(3'd1);
                    end
                end
            end
            S_START_HOLD: begin
                if (tmr_exp) begin
                    scl_lo_n = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = us_wait(3'd5);
                    state_n  = S_START_LOW;
                end
            end
            S_START_LOW: begin
                if (tmr_exp) state_n = S_DONE;
            end
            S_STOP_SETUP: begin
                if (tmr_exp) begin
                    sda_lo_n = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = us_wait(3'd5);
                    state_n  = S_STOP_BUF;
                end
            end
            S_STOP_BUF: begin
                if (tmr_exp) state_n = S_DONE;
            end
            S_BIT_SETUP: begin
                if (tmr_exp) begin
                    scl_lo_n   = 1'b0;
                    rty_n      = '0;
                    rise_ret_n = S_BIT_HIGH;
                    tmr_load   = 1'b1;
                    state_n    = S_SCL_RISE;
                end
            end
            S_BIT_HIGH: begin
                if (tmr_exp) begin
                    if (!is_write) shreg_n = {shreg[6:0], sda_s};
                    scl_lo_n = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = us_wait(3'd5);
                    state_n  = S_BIT_LOW;
                end
            end
            S_BIT_LOW: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = us_wait(3'd1);
                    if (bit_cnt == 3'd7) begin
                        sda_lo_n = is_write ? 1'b0 : ~rd_nack;
                        state_n  = S_ACK_SETUP;
                    end else begin
                        bit_cnt_n = bit_cnt + 3'd1;
                        if (is_write) begin
                            shreg_n  = {shreg[6:0], 1'b0};
                            sda_lo_n = ~shreg[6];
                        end
                        state_n = S_BIT_SETUP;
                    end
                end
            end
            S_ACK_SETUP: begin
                if (tmr_exp) begin
                    scl_lo_n   = 1'b0;
                    rty_n      = '0;
                    rise_ret_n = S_ACK_HIGH;
                    tmr_load   = 1'b1;
                    state_n    = S_SCL_RISE;
                end
            end
            S_ACK_HIGH: begin
                if (tmr_exp) begin
                    if (is_write) begin
                        nack_n   = sda_s;
                        sda_lo_n = 1'b1;
                    end else begin
                        rx_n = shreg;
                    end
                    scl_lo_n = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = us_wait(3'd5);
                    state_n  = S_ACK_LOW;
                end
            end
            S_ACK_LOW: begin
                if (tmr_exp) state_n = S_DONE;
            end
            S_DONE: state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // Datapath and output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_ret <= S_IDLE;
            cur_op   <= OP_START;
            scl_lo   <= 1'b0;
            sda_lo   <= 1'b0;
            err_r    <= 1'b0;
            nack_r   <= 1'b0;
            shreg    <= '0;
            rx_r     <= '0;
            cmp_r    <= '0;
            force_r  <= 1'b0;
            cmp_en_r <= 1'b0;
            bit_cnt  <= '0;
            rty      <= '0;
        end else begin
            rise_ret <= rise_ret_n;
            cur_op   <= cur_op_n;
            scl_lo   <= scl_lo_n;
            sda_lo   <= sda_lo_n;
            err_r    <= err_n;
            nack_r   <= nack_n;
            shreg    <= shreg_n;
            rx_r     <= rx_n;
            cmp_r    <= cmp_n;
            force_r  <= force_n;
            cmp_en_r <= cmp_en_n;
            bit_cnt  <= bit_cnt_n;
            rty      <= rty_n;
        end
    end

    assign cmd_ready     = (state == S_IDLE);
    assign done          = (state == S_DONE);
    assign err           = err_r;
    assign ack_nack      = nack_r;
    assign rx_data       = rx_r;
    assign scl_drive_low = scl_lo;
    assign sda_drive_low = sda_lo;

    // Byte command on a high clock line is refused on the next cycle.
    assert_byte_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op[1] && scl_s) |=> (done && err));

    // Completion lasts one cycle and returns to idle.
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready));

    // A stretch timeout inside a byte command leaves SDA held low.
    assert_timeout_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err && is_byte && $past(state) == S_SCL_RISE) |-> sda_drive_low);

    // Data line is frozen while the master holds the clock high.
    assert_sda_stable_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BIT_HIGH && $past(state) == S_BIT_HIGH) |-> $stable(sda_drive_low));

endmodule

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TPU        = 2;
    localparam int EXW        = 4;
    localparam int LMW        = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic           cmd_ready;
    logic [1:0]     cmd_op = 2'd0;
    logic [7:0]     cmd_wdata = 8'h00;
    logic           cmd_force_nack = 1'b0;
    logic           cmd_cmp_en = 1'b0;
    logic [7:0]     cmd_cmp_byte = 8'h00;
    logic [EXW-1:0] cfg_extra_us = '0;
    logic [LMW-1:0] cfg_stretch_limit = '0;
    logic           done, err, ack_nack;
    logic [7:0]     rx_data;
    logic           scl_drive_low, sda_drive_low;
    logic           scl_line, sda_line;

    // Slave model state.
    logic       slave_scl_low = 1'b0;
    logic       force_sda_low = 1'b0;
    logic       rd_mode = 1'b0, wr_mode = 1'b0, wr_ack = 1'b0;
    logic [7:0] rd_byte = 8'h00;
    logic       clr = 1'b0;
    logic       scl_q = 1'b1;
    logic [3:0] rcnt = '0, fcnt = '0;
    logic [7:0] cap = '0;
    logic       ack_seen = 1'b0;
    logic       slave_sda_low;

    int tests = 0;
    int fails = 0;
    logic       r_err, r_nack;
    logic [7:0] r_rx;

    time t_sda_lo = 0, t_scl_rel = 0;
    int  start_gap = 0, stop_gap = 0, hi_len = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign slave_sda_low = force_sda_low
                         || (rd_mode && fcnt < 4'd8 && !rd_byte[3'd7 - fcnt[2:0]])
                         || (wr_mode && fcnt == 4'd8 && wr_ack);
    assign scl_line = !(scl_drive_low || slave_scl_low);
    assign sda_line = !(sda_drive_low || slave_sda_low);

    i2c_byte_master #(.TICKS_PER_US(TPU), .EXTRA_W(EXW), .LIMIT_W(LMW)) u_i2c_byte_master (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .cmd_force_nack(cmd_force_nack),
        .cmd_cmp_en(cmd_cmp_en), .cmd_cmp_byte(cmd_cmp_byte),
        .cfg_extra_us(cfg_extra_us), .cfg_stretch_limit(cfg_stretch_limit),
        .done(done), .err(err), .ack_nack(ack_nack), .rx_data(rx_data),
        .scl_drive_low(scl_drive_low), .scl_in(scl_line),
        .sda_drive_low(sda_drive_low), .sda_in(sda_line)
    );

    // Slave edge tracking on the wired bus.
    always @(posedge clk) begin
        scl_q <= scl_line;
        if (clr) begin
            rcnt <= '0;
            fcnt <= '0;
        end else begin
            if (scl_line && !scl_q) begin
                if (rcnt < 4'd8) cap <= {cap[6:0], sda_line};
                if (rcnt == 4'd8) ack_seen <= sda_line;
                rcnt <= rcnt + 4'd1;
            end
            if (!scl_line && scl_q) fcnt <= fcnt + 4'd1;
        end
    end

    // Pin-edge timing measurement.
    always @(posedge sda_drive_low) t_sda_lo = $time;
    always @(negedge scl_drive_low) t_scl_rel = $time;
    always @(posedge scl_drive_low) begin
        start_gap = int'((($time - t_sda_lo)) / CLK_PERIOD);
        hi_len    = int'((($time - t_scl_rel)) / CLK_PERIOD);
    end
    always @(negedge sda_drive_low) stop_gap = int'((($time - t_scl_rel)) / CLK_PERIOD);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [7:0] wd,
                           input logic fn, input logic ce, input logic [7:0] cb);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd;
        cmd_force_nack = fn; cmd_cmp_en = ce; cmd_cmp_byte = cb;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        r_err = err; r_nack = ack_nack; r_rx = rx_data;
        @(negedge clk);
    endtask

    task automatic clear_slave();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] v, input logic slave_acks);
        clear_slave();
        wr_mode = 1'b1; wr_ack = slave_acks;
        run_cmd(2'd2, v, 1'b0, 1'b0, 8'h00);
        wr_mode = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] v, input logic fn, input logic ce, input logic [7:0] cb);
        clear_slave();
        rd_byte = v; rd_mode = 1'b1;
        run_cmd(2'd3, 8'h00, fn, ce, cb);
        rd_mode = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R12 watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(!scl_drive_low && !sda_drive_low, "R1 lines released", {scl_drive_low, sda_drive_low}, 0);
        check(cmd_ready && !done, "R1 ready/done", {cmd_ready, done}, 2);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R5 byte commands rejected on a high clock
        run_cmd(2'd2, 8'h55, 1'b0, 1'b0, 8'h00);
        check(r_err, "R5 write rejected", r_err, 1);
        check(!scl_drive_low && !sda_drive_low, "R5 lines unchanged", {scl_drive_low, sda_drive_low}, 0);
        run_cmd(2'd3, 8'h00, 1'b0, 1'b0, 8'h00);
        check(r_err, "R5 read rejected", r_err, 1);

        // R2 busy data line blocks START
        force_sda_low = 1'b1;
        run_cmd(2'd0, 8'h00, 1'b0, 1'b0, 8'h00);
        check(r_err, "R2 start on low SDA", r_err, 1);
        check(!scl_drive_low, "R2 SCL left released", scl_drive_low, 0);
        force_sda_low = 1'b0;
        repeat (3) @(negedge clk);

        // R12 handshake: ready drops while busy
        cfg_extra_us = 4'd2;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(!cmd_ready, "R12 ready low while busy", cmd_ready, 0);
        while (!done) @(negedge clk);
        r_err = err;
        @(negedge clk);
        check(!done && cmd_ready, "R12 done single pulse", {done, cmd_ready}, 1);
        // R3 START timing with extra delay 2
        check(!r_err, "R3 start ok", r_err, 0);
        check(start_gap == (4 + 2) * TPU, "R3 SDA-to-SCL gap", start_gap, (4 + 2) * TPU);
        check(scl_drive_low && sda_drive_low, "R3 lines held low", {scl_drive_low, sda_drive_low}, 3);

        // R6/R7 single write with timing
        do_write(8'hA5, 1'b1);
        check(!r_err && cap == 8'hA5, "R6 write byte MSB first", cap, 8'hA5);
        check(hi_len == 3 + (4 + 2) * TPU, "R6 SCL high length", hi_len, 3 + (4 + 2) * TPU);
        check(!r_nack, "R7 ack reported", r_nack, 0);
        check(sda_drive_low, "R7 SDA held after ack", sda_drive_low, 1);

        // R4 STOP
        run_cmd(2'd1, 8'h00, 1'b0, 1'b0, 8'h00);
        check(!r_err, "R4 stop ok", r_err, 0);
        check(stop_gap == 3 + (4 + 2) * TPU, "R4 SCL-to-SDA gap", stop_gap, 3 + (4 + 2) * TPU);
        check(!scl_drive_low && !sda_drive_low, "R4 lines released", {scl_drive_low, sda_drive_low}, 0);

        // Exhaustive write sweep (R6, R7)
        cfg_extra_us = '0;
        run_cmd(2'd0, 8'h00, 1'b0, 1'b0, 8'h00);
        for (int v = 0; v < 256; v++) begin
            do_write(8'(v), ~v[0]);
            check(!r_err && cap == 8'(v), "R6 sweep byte", cap, v);
            check(r_nack == v[0], "R7 sweep ack", r_nack, v[0]);
        end

        // Exhaustive read sweep with rotating acknowledge policy (R8, R9)
        for (int v = 0; v < 256; v++) begin
            int  pol = v % 4;
            logic exp_nack;
            logic [7:0] cb;
            cb = (pol == 3) ? (8'(v) ^ 8'h5A) : 8'(v);
            exp_nack = (pol == 1) || (pol == 3);
            do_read(8'(v), pol == 1, pol >= 2, cb);
            check(!r_err && r_rx == 8'(v), "R8 read byte", r_rx, v);
            check(ack_seen == exp_nack, "R9 read ack policy", ack_seen, exp_nack);
        end
        run_cmd(2'd1, 8'h00, 1'b0, 1'b0, 8'h00);
        check(!r_err, "R4 stop after sweep", r_err, 0);

        // R10 stretch inside limit 3
        run_cmd(2'd0, 8'h00, 1'b0, 1'b0, 8'h00);
        cfg_stretch_limit = 8'd3;
        slave_scl_low = 1'b1;
        fork
            do_write(8'h3C, 1'b1);
            begin repeat (10) @(negedge clk); slave_scl_low = 1'b0; end
        join
        check(!r_err && cap == 8'h3C, "R10 short stretch passes", {r_err, cap}, 8'h3C);

        // R10 zero limit means 25 retries
        cfg_stretch_limit = 8'd0;
        slave_scl_low = 1'b1;
        fork
            do_write(8'h96, 1'b1);
            begin repeat (32) @(negedge clk); slave_scl_low = 1'b0; end
        join
        check(!r_err && cap == 8'h96, "R10 default limit 25", {r_err, cap}, 8'h96);

        // R11 endless stretch times out
        cfg_stretch_limit = 8'd3;
        slave_scl_low = 1'b1;
        do_write(8'h11, 1'b1);
        check(r_err, "R11 timeout error", r_err, 1);
        check(sda_drive_low, "R11 SDA held low", sda_drive_low, 1);
        slave_scl_low = 1'b0;
        repeat (4) @(negedge clk);
        run_cmd(2'd1, 8'h00, 1'b0, 1'b0, 8'h00);
        check(!r_err && !sda_drive_low && !scl_drive_low, "R4 stop recovers bus", r_err, 0);

        summary();
        $finish;
    end
endmodule